// File: doc/BRIEF.md
# Channel Diagnostic Status Generator

This block produces the diagnostic status bit for each channel of a multi-channel low-side power switch. For each channel it takes the effective on/off command, the latched protection fault from the channel's protection controller, an undercurrent flag that is valid while the channel is on, and a low-drain-voltage flag that is valid while the channel is off. From these it builds one status bit per channel. With no fault, the bit follows the switching state. When a failure is reported, the bit is inverted.

A status consumer that samples slowly needs a steady level under pulse-width modulation. For this reason the high-to-low edge of the normal level is held for a long, programmable number of cycles, so off-gaps in a PWM train do not reach the status bit. The off-state open-load flag is filtered against short drain transients. Every failure source must then persist through a failure-extension window before it is reported. After reset, and after each exit from standby, a wake window runs. During this window the status is forced low and a valid flag stays low. All times are counted in clock cycles.

Top module: `diag_status_gen`

## Requirements
- R1: With no reported failure, a channel's status is 1 while its normal level is on and 0 once that level has returned to off.
- R2: A command sampled high sets the channel's normal level at that clock edge, so the status reads 1 after the edge.
- R3: The normal level falls only after HOLD_CYC consecutive edges with the command low. An off-gap of fewer edges leaves the status static at 1. A gap of HOLD_CYC or more lets it fall at the HOLD_CYC-th edge.
- R4: The off-state open-load flag counts only while the command is low, and only after it has held for OLF_CYC consecutive edges. A shorter glitch has no effect on the status.
- R5: A failure source (protection fault, accepted off-state open load, or on-state undercurrent) is reported only after it has held for FEXT_CYC consecutive edges. A shorter pulse is never reported. A failure that goes away is no longer reported within two edges.
- R6: A reported failure inverts the status: 0 instead of 1 while on, and 1 instead of 0 while off.
- R7: The on-state undercurrent flag is ignored while the command is low.
- R8: After reset is released, and after standby returns high, valid stays 0 and every status bit stays 0 for WAKE_CYC edges. Valid becomes 1 at the WAKE_CYC-th edge.
- R9: A standby input sampled low clears valid and forces every status bit to 0 from that edge on.
- R10: Channels are independent. Stimulus on one channel never changes another channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | 1 = active, 0 = standby |
| cmd | input | NCH | Effective on/off command per channel |
| prot_flt | input | NCH | Latched overload or overtemperature fault per channel |
| ol_on | input | NCH | Undercurrent flag, meaningful while on |
| ol_off | input | NCH | Low drain voltage flag, meaningful while off |
| valid | output | 1 | Status bits are defined |
| status | output | NCH | Diagnostic status per channel |

## Verification
The bench builds the block with two channels, HOLD_CYC = 8, OLF_CYC = 5, FEXT_CYC = 3 and WAKE_CYC = 10. These small windows let every off-gap length from 1 to HOLD_CYC+2 be swept, on both sides of the hold boundary. They also let every off-state glitch length up to the point where the filter and the extension window together first report a failure be swept, and the protection pulse length be swept across the extension window. Each sweep is checked cycle by cycle against arithmetic thresholds. The wake window and the standby exit run short enough to check at every edge, while the second channel is watched for disturbance.

// File: rtl/diag_status_gen.sv
module diag_status_gen #(
  parameter int NCH      = 4,
  parameter int HOLD_CYC = 240000,
  parameter int OLF_CYC  = 6000,
  parameter int FEXT_CYC = 6000,
  parameter int WAKE_CYC = 400000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stby_n,
  input  logic [NCH-1:0] cmd,
  input  logic [NCH-1:0] prot_flt,
  input  logic [NCH-1:0] ol_on,
  input  logic [NCH-1:0] ol_off,
  output logic           valid,
  output logic [NCH-1:0] status
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int OW = $clog2(OLF_CYC + 1);
  localparam int FW = $clog2(FEXT_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
  localparam logic [OW-1:0] OLF_LAST  = OW'(OLF_CYC - 1);
  localparam logic [FW-1:0] FEXT_LAST = FW'(FEXT_CYC - 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

  logic [NCH-1:0] norm_q, olf_q, flt_q, flt_raw;
  logic [WW-1:0]  wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= '0;
      valid    <= 1'b0;
    end else if (!stby_n) begin
      wake_cnt <= '0;
      valid    <= 1'b0;
    end else if (!valid) begin
      if (wake_cnt == WAKE_LAST) valid <= 1'b1;
      else wake_cnt <= wake_cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [HW-1:0] off_cnt;
    logic [OW-1:0] olf_cnt;
    logic [FW-1:0] flt_cnt;
    logic          norm_r, olf_r, flt_r;
    wire           olf_cond = ol_off[c] & ~cmd[c];

    assign flt_raw[c] = prot_flt[c] | olf_r | (ol_on[c] & cmd[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_cnt <= '0;
        norm_r  <= 1'b0;
      end else if (!stby_n) begin
        off_cnt <= '0;
        norm_r  <= 1'b0;
      end else if (cmd[c]) begin
        off_cnt <= '0;
        norm_r  <= 1'b1;
      end else if (norm_r) begin
        if (off_cnt == HOLD_LAST) begin
          norm_r  <= 1'b0;
          off_cnt <= '0;
        end else off_cnt <= off_cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        olf_cnt <= '0;
        olf_r   <= 1'b0;
      end else if (!stby_n || !olf_cond) begin
        olf_cnt <= '0;
        olf_r   <= 1'b0;
      end else if (!olf_r) begin
        if (olf_cnt == OLF_LAST) olf_r <= 1'b1;
        else olf_cnt <= olf_cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt_cnt <= '0;
        flt_r   <= 1'b0;
      end else if (!stby_n || !flt_raw[c]) begin
        flt_cnt <= '0;
        flt_r   <= 1'b0;
      end else if (!flt_r) begin
        if (flt_cnt == FEXT_LAST) flt_r <= 1'b1;
        else flt_cnt <= flt_cnt + 1'b1;
      end
    end

    assign norm_q[c] = norm_r;
    assign olf_q[c]  = olf_r;
    assign flt_q[c]  = flt_r;
    assign status[c] = valid & (norm_r ^ flt_r);
  end

endmodule

module diag_status_gen_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           stby_n,
  input logic [NCH-1:0] cmd,
  input logic [NCH-1:0] ol_off,
  input logic           valid,
  input logic [NCH-1:0] status,
  input logic [NCH-1:0] norm_q,
  input logic [NCH-1:0] olf_q,
  input logic [NCH-1:0] flt_q,
  input logic [NCH-1:0] flt_raw
);

  // R8
  status_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> status == '0);

  // R9
  stby_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> !valid);

  // R2
  cmd_sets_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !stby_n)
    (valid && $past(valid)) |-> (($past(cmd) & ~norm_q) == '0));

  // R4
  olf_needs_off_cond_chk: assert property (@(posedge clk) disable iff (!rst_n || !stby_n)
    (valid && $past(valid)) |-> ((olf_q & ~$past(ol_off & ~cmd)) == '0));

  // R5
  flt_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n || !stby_n)
    (valid && $past(valid)) |-> ((flt_q & ~$past(flt_raw)) == '0));

endmodule

bind diag_status_gen diag_status_gen_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cmd(cmd), .ol_off(ol_off),
  .valid(valid), .status(status), .norm_q(norm_q), .olf_q(olf_q),
  .flt_q(flt_q), .flt_raw(flt_raw)
);

// File: tb/diag_status_gen_bench.sv
`timescale 1ns/1ps
module diag_status_gen_bench;
  localparam int NCH = 2, HOLD = 8, OLF = 5, FEXT = 3, WAKE = 10;

  logic clk = 0, rst_n = 0, stby_n = 1, done = 0;
  logic [NCH-1:0] cmd = '0, prot_flt = '0, ol_on = '0, ol_off = '0;
  logic valid;
  logic [NCH-1:0] status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  diag_status_gen #(.NCH(NCH), .HOLD_CYC(HOLD), .OLF_CYC(OLF), .FEXT_CYC(FEXT),
    .WAKE_CYC(WAKE)) u_diag_status_gen (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cmd(cmd), .prot_flt(prot_flt),
    .ol_on(ol_on), .ol_off(ol_off), .valid(valid), .status(status));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R8 reset valid", valid, 1'b0);
    chk("R8 reset status", status[0], 1'b0);
    cmd[0] = 1;
    @(negedge clk); rst_n = 1;
    for (int j = 1; j <= WAKE; j++) begin
      tick();
      chk("R8 wake valid", valid, j >= WAKE);
      chk("R8 wake status", status[0], j >= WAKE);
    end
    cmd[0] = 0;
    repeat (HOLD + 2) tick();
    chk("R1 idle low", status[0], 1'b0);

    for (int g = 1; g <= HOLD + 2; g++) begin
      cmd[0] = 1; tick();
      chk("R2 on", status[0], 1'b1);
      cmd[0] = 0;
      for (int j = 1; j <= g; j++) begin
        tick();
        chk("R3 gap", status[0], j < HOLD);
        chk("R10 quiet ch1", status[1], 1'b0);
      end
      cmd[0] = 1; tick();
      chk("R2 re-on", status[0], 1'b1);
      cmd[0] = 0;
      repeat (HOLD) tick();
      chk("R1 back off", status[0], 1'b0);
    end

    for (int l = 1; l <= OLF + FEXT + 1; l++) begin
      ol_off[0] = 1;
      for (int j = 1; j <= l; j++) begin
        tick();
        chk("R4 R6 ol_off", status[0], j >= OLF + FEXT);
      end
      ol_off[0] = 0;
      repeat (3) tick();
      chk("R5 ol_off cleared", status[0], 1'b0);
    end

    ol_on[0] = 1;
    for (int j = 1; j <= FEXT + 4; j++) begin
      tick();
      chk("R7 ol_on ignored off", status[0], 1'b0);
    end
    cmd[0] = 1;
    for (int j = 1; j <= FEXT + 2; j++) begin
      tick();
      chk("R5 R6 ol_on", status[0], j < FEXT);
    end
    cmd[0] = 0; ol_on[0] = 0;
    repeat (HOLD + 3) tick();
    chk("R1 after ol_on", status[0], 1'b0);

    cmd[0] = 1; tick();
    for (int p = 1; p <= FEXT + 1; p++) begin
      prot_flt[0] = 1;
      for (int j = 1; j <= p; j++) begin
        tick();
        chk("R5 R6 prot on", status[0], j < FEXT);
      end
      prot_flt[0] = 0;
      repeat (3) tick();
      chk("R5 prot cleared", status[0], 1'b1);
    end
    cmd[0] = 0;
    repeat (HOLD + 2) tick();
    prot_flt[0] = 1;
    for (int j = 1; j <= FEXT; j++) begin
      tick();
      chk("R6 prot off", status[0], j >= FEXT);
    end
    prot_flt[0] = 0;
    repeat (3) tick();
    chk("R5 prot off cleared", status[0], 1'b0);

    ol_off[1] = 1;
    for (int j = 1; j <= OLF + FEXT; j++) begin
      tick();
      chk("R10 ch1 ol_off", status[1], j >= OLF + FEXT);
      chk("R10 ch0 untouched", status[0], 1'b0);
    end

    stby_n = 0; tick();
    chk("R9 valid", valid, 1'b0);
    chk("R9 status", status[1], 1'b0);
    repeat (4) tick();
    chk("R9 held", status[1], 1'b0);
    stby_n = 1;
    for (int j = 1; j <= WAKE; j++) begin
      tick();
      chk("R8 restart valid", valid, j >= WAKE);
      if (j < WAKE) chk("R8 restart status", status[1], 1'b0);
    end
    ol_off[1] = 0;
    repeat (3) tick();
    chk("R5 ch1 cleared", status[1], 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule